// File: doc/BRIEF.md
# ATM Cell Boundary Locator

This block recovers the position of ATM cells inside the octet stream of a single E1/T1 line. Every octet that arrives with its valid strobe enters a four-octet window; the block computes the header check code over that window, folds a programmable coset into it and compares the result with the octet that follows the window. A three-state search machine uses the outcome. While searching, it tests every octet position. Once it has a candidate, it tests only the position one cell length (53 octets) after the last header it accepted.

The state is reported as a two-bit code. One-cycle pulses mark the moment delineation is lost, the moment it is regained, and every header octet that passes the check. A persistence timer starts when delineation is lost and raises a further alarm if delineation is not regained in time. A software-driven control can hold the machine in its search state without producing a loss alarm. Octet descrambling, single-bit header repair and cell storage are handled elsewhere.

Top module: `atm_cell_delin`

## Requirements
- R1: The check code is CRC-8 with generator x^8+x^2+x+1 (0x07), initial value 0, taken over the four octets before the current one in arrival order, most significant bit first. The result is XORed with `coset_i` and compared with the current octet. `hdr_ok_o` pulses for one cycle after every octet at which a check was made and matched. An all-zero header with coset 0x55 needs a check octet of 0x55.
- R2: In search (status 00), every valid octet is checked once at least four octets have been taken in since reset or since force-hunt was released. The first match moves the status to 01 in the next cycle.
- R3: The status code is 00 for search, 01 for candidate and 10 for locked. The code 11 never appears.
- R4: In candidate and locked, a check is made only at the 53rd valid octet after the previous checked octet. In candidate, `delta_i` consecutive matching checks move the status to 10. Any failing check returns it to 00.
- R5: In locked, `alpha_i` consecutive failing checks return the status to 00. A matching check clears the failure run.
- R6: `ocd_start_o` pulses for one cycle when locked is left because of failing checks. `ocd_end_o` pulses for one cycle whenever locked is entered.
- R7: At the `ocd_start_o` event, a timer is loaded with 128 × `lcd_period_i` and then counts down on each `tick_i`. A tick that finds a count of 1 or less raises a one-cycle `lcd_start_o` pulse. The next entry into locked raises a one-cycle `lcd_end_o` pulse if `lcd_start_o` had fired.
- R8: While `force_hunt_i` is high, the status is 00, octets are ignored, all counters and the octet window are cleared, and no `ocd_start_o` is produced.
- R9: After a synchronous active-low reset, the status is 00 and all pulse outputs are low.
- R10: `cell_start_o` pulses for one cycle after each checked octet handled in locked, whether or not it matched.
- R11: A cycle with `octet_vld_i` low advances nothing: the status is held and no check pulse appears.
- R12: A value of 0 in `alpha_i` or in `delta_i` behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| octet_i | input | 8 | Received line octet |
| octet_vld_i | input | 1 | Octet strobe |
| alpha_i | input | 4 | Failing checks that end lock (default 7) |
| delta_i | input | 4 | Matching checks needed to lock (default 6) |
| coset_i | input | 8 | Pattern XORed into the computed check code (default 0x55) |
| force_hunt_i | input | 1 | Holds the machine in search |
| lcd_period_i | input | 16 | Persistence time in units of 128 ticks |
| tick_i | input | 1 | Persistence timer decrement strobe |
| cell_start_o | output | 1 | Pulse after each header position handled in locked |
| hdr_ok_o | output | 1 | Pulse after each matching check |
| status_o | output | 2 | 00 search, 01 candidate, 10 locked |
| ocd_start_o | output | 1 | Pulse when delineation is lost |
| ocd_end_o | output | 1 | Pulse when lock is entered |
| lcd_start_o | output | 1 | Pulse when loss has persisted |
| lcd_end_o | output | 1 | Pulse when lock returns after a persistent loss |

## Verification
A wrong window or a wrong check code shows first as a missing or extra `hdr_ok_o` pulse on the cycle after the check octet. If the position counter is off by one, the status falls from 01 back to 00 one cell after the first match instead of reaching 10. A failure counter that is not cleared turns isolated bad headers into an early `ocd_start_o`, at most alpha cells later. A wrong timer load moves `lcd_start_o` away from its tick count by at least one cycle. The bench compares every output against a behavioural model on every clock, so each of these shows within the cycle it arises.

// File: rtl/atm_delin_pkg.sv
// Shared types and helpers for the ATM cell boundary locator.
// Assumes octets arrive most significant bit first on the line.
package atm_delin_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'b00,
        ST_PRESYNC = 2'b01,
        ST_SYNC    = 2'b10
    } delin_state_e;

    localparam logic [7:0] HEC_POLY = 8'h07;

    // One octet of a CRC-8 update, MSB first.
    function automatic logic [7:0] crc8_octet(input logic [7:0] crc_in,
                                              input logic [7:0] octet);
        logic [7:0] c;
        c = crc_in ^ octet;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/atm_hec_check.sv
// Keeps the last HDR_OCTETS octets of the stream and tests whether the
// current octet equals their CRC-8 XOR coset. Assumes clear_i has
// priority over a valid octet in the same cycle.
module atm_hec_check
    import atm_delin_pkg::*;
#(
    parameter int HDR_OCTETS = 4,
    parameter int OCTET_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               vld_i,
    input  logic [OCTET_W-1:0] octet_i,
    input  logic [OCTET_W-1:0] coset_i,
    output logic               win_full_o,
    output logic               hec_hit_o
);
    localparam int FILL_W = $clog2(HDR_OCTETS + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HDR_OCTETS);

    logic [HDR_OCTETS-1:0][OCTET_W-1:0] win_q;
    logic [FILL_W-1:0]                  fill_q;
    logic [OCTET_W-1:0]                 crc_c;

    // Shift the octet window; entry 0 is the oldest octet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (vld_i && !clear_i) begin
            for (int i = 0; i < HDR_OCTETS - 1; i++) begin
                win_q[i] <= win_q[i+1];
            end
            win_q[HDR_OCTETS-1] <= octet_i;
        end
    end

    // Count how many window entries hold real octets.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            fill_q <= '0;
        end else if (vld_i && fill_q != FILL_MAX) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // CRC-8 over the window, oldest octet first.
    always_comb begin
        crc_c = '0;
        for (int i = 0; i < HDR_OCTETS; i++) begin
            crc_c = crc8_octet(crc_c, win_q[i]);
        end
    end

    assign win_full_o = (fill_q == FILL_MAX);
    assign hec_hit_o  = win_full_o && ((crc_c ^ coset_i) == octet_i);

    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !win_full_o);

    p_fill_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !clear_i && !win_full_o) |=> fill_q == $past(fill_q) + 1'b1);

endmodule

// File: rtl/atm_delin_fsm.sv
// Search/candidate/locked machine. Tests every octet in search and only
// the octet one cell after the last checked header otherwise. Assumes the
// hit input is already qualified by a full window.
module atm_delin_fsm
    import atm_delin_pkg::*;
#(
    parameter int CELL_OCTETS = 53,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_hunt_i,
    input  logic             vld_i,
    input  logic             hec_hit_i,
    input  logic [CNT_W-1:0] alpha_i,
    input  logic [CNT_W-1:0] delta_i,
    output logic [1:0]       state_o,
    output logic             hdr_ok_o,
    output logic             cell_start_o,
    output logic             ocd_start_o,
    output logic             ocd_end_o,
    output logic             lose_evt_o,
    output logic             lock_evt_o
);
    localparam int POS_W = $clog2(CELL_OCTETS);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_OCTETS - 1);

    delin_state_e     state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [CNT_W-1:0] good_q, good_d, bad_q, bad_d;
    logic [CNT_W-1:0] alpha_eff, delta_eff;
    logic [CNT_W:0]   good_next, bad_next;
    logic             hdr_d, cell_d, lose_c, lock_c;

    // Zero thresholds behave as one.
    assign alpha_eff = (alpha_i == '0) ? CNT_W'(1) : alpha_i;
    assign delta_eff = (delta_i == '0) ? CNT_W'(1) : delta_i;
    assign good_next = {1'b0, good_q} + 1'b1;
    assign bad_next  = {1'b0, bad_q} + 1'b1;

    // Next-state decision for one octet.
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        good_d  = good_q;
        bad_d   = bad_q;
        hdr_d   = 1'b0;
        cell_d  = 1'b0;
        lose_c  = 1'b0;
        lock_c  = 1'b0;
        if (force_hunt_i) begin
            state_d = ST_HUNT;
            pos_d   = '0;
            good_d  = '0;
            bad_d   = '0;
        end else if (vld_i) begin
            if (state_q == ST_HUNT) begin
                pos_d = pos_q + 1'b1;
                if (hec_hit_i) begin
                    hdr_d   = 1'b1;
                    state_d = ST_PRESYNC;
                    pos_d   = '0;
                    good_d  = '0;
                end
            end else if (pos_q == LAST_POS) begin
                pos_d  = '0;
                hdr_d  = hec_hit_i;
                cell_d = (state_q == ST_SYNC);
                if (state_q == ST_PRESYNC) begin
                    if (!hec_hit_i) begin
                        state_d = ST_HUNT;
                        good_d  = '0;
                    end else if (good_next >= {1'b0, delta_eff}) begin
                        state_d = ST_SYNC;
                        good_d  = '0;
                        bad_d   = '0;
                        lock_c  = 1'b1;
                    end else begin
                        good_d = good_next[CNT_W-1:0];
                    end
                end else begin
                    if (hec_hit_i) begin
                        bad_d = '0;
                    end else if (bad_next >= {1'b0, alpha_eff}) begin
                        state_d = ST_HUNT;
                        bad_d   = '0;
                        lose_c  = 1'b1;
                    end else begin
                        bad_d = bad_next[CNT_W-1:0];
                    end
                end
            end else begin
                pos_d = pos_q + 1'b1;
            end
        end
    end

    // State, counters and registered pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_HUNT;
            pos_q        <= '0;
            good_q       <= '0;
            bad_q        <= '0;
            hdr_ok_o     <= 1'b0;
            cell_start_o <= 1'b0;
            ocd_start_o  <= 1'b0;
            ocd_end_o    <= 1'b0;
        end else begin
            state_q      <= state_d;
            pos_q        <= pos_d;
            good_q       <= good_d;
            bad_q        <= bad_d;
            hdr_ok_o     <= hdr_d;
            cell_start_o <= cell_d;
            ocd_start_o  <= lose_c;
            ocd_end_o    <= lock_c;
        end
    end

    assign state_o    = state_q;
    assign lose_evt_o = lose_c;
    assign lock_evt_o = lock_c;

    p_legal_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'b11);

    p_no_skip_to_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |=> (state_q != ST_SYNC));

    p_lock_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && $past(state_q) != ST_SYNC) |-> $past(hec_hit_i && vld_i));

    p_loss_from_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ocd_start_o |-> (state_q == ST_HUNT && $past(state_q) == ST_SYNC));

    p_force_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_hunt_i |=> (state_q == ST_HUNT && !ocd_start_o && !hdr_ok_o));

    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && !force_hunt_i) |=> ($stable(state_q) && !hdr_ok_o && !cell_start_o));

endmodule

// File: rtl/atm_lcd_timer.sv
// Persistence timer for loss of delineation. Armed by a loss event,
// disarmed by a lock event; expiry raises a one-cycle start pulse and the
// following lock raises an end pulse. Assumes arm and disarm never coincide.
module atm_lcd_timer #(
    parameter int PERIOD_W    = 16,
    parameter int SCALE_SHIFT = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm_i,
    input  logic                disarm_i,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                lcd_start_o,
    output logic                lcd_end_o
);
    localparam int TMR_W = PERIOD_W + SCALE_SHIFT;
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    logic [TMR_W-1:0] cnt_q;
    logic             armed_q, active_q;

    // Load, count down and report the persistence window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            armed_q     <= 1'b0;
            active_q    <= 1'b0;
            lcd_start_o <= 1'b0;
            lcd_end_o   <= 1'b0;
        end else begin
            lcd_start_o <= 1'b0;
            lcd_end_o   <= 1'b0;
            if (disarm_i) begin
                lcd_end_o <= active_q;
                armed_q   <= 1'b0;
                active_q  <= 1'b0;
            end else if (arm_i) begin
                armed_q  <= 1'b1;
                active_q <= 1'b0;
                cnt_q    <= {period_i, {SCALE_SHIFT{1'b0}}};
            end else if (tick_i && armed_q && !active_q) begin
                if (cnt_q <= ONE) begin
                    active_q    <= 1'b1;
                    lcd_start_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    p_start_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_start_o |-> ($past(tick_i) && $past(armed_q)));

    p_end_needs_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_end_o |-> ($past(active_q) && $past(disarm_i)));

endmodule

// File: rtl/atm_cell_delin.sv
// Top of the ATM cell boundary locator: octet window with check code,
// delineation machine and loss persistence timer. Assumes one octet per
// valid cycle and configuration that is quasi-static.
module atm_cell_delin
    import atm_delin_pkg::*;
#(
    parameter int OCTET_W     = 8,
    parameter int HDR_OCTETS  = 4,
    parameter int CELL_OCTETS = 53,
    parameter int CNT_W       = 4,
    parameter int PERIOD_W    = 16,
    parameter int SCALE_SHIFT = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OCTET_W-1:0]  octet_i,
    input  logic                octet_vld_i,
    input  logic [CNT_W-1:0]    alpha_i,
    input  logic [CNT_W-1:0]    delta_i,
    input  logic [OCTET_W-1:0]  coset_i,
    input  logic                force_hunt_i,
    input  logic [PERIOD_W-1:0] lcd_period_i,
    input  logic                tick_i,
    output logic                cell_start_o,
    output logic                hdr_ok_o,
    output logic [1:0]          status_o,
    output logic                ocd_start_o,
    output logic                ocd_end_o,
    output logic                lcd_start_o,
    output logic                lcd_end_o
);
    logic win_full, hec_hit, lose_evt, lock_evt;

    atm_hec_check #(
        .HDR_OCTETS (HDR_OCTETS),
        .OCTET_W    (OCTET_W)
    ) u_hec (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (force_hunt_i),
        .vld_i      (octet_vld_i),
        .octet_i    (octet_i),
        .coset_i    (coset_i),
        .win_full_o (win_full),
        .hec_hit_o  (hec_hit)
    );

    atm_delin_fsm #(
        .CELL_OCTETS (CELL_OCTETS),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_hunt_i (force_hunt_i),
        .vld_i        (octet_vld_i),
        .hec_hit_i    (hec_hit),
        .alpha_i      (alpha_i),
        .delta_i      (delta_i),
        .state_o      (status_o),
        .hdr_ok_o     (hdr_ok_o),
        .cell_start_o (cell_start_o),
        .ocd_start_o  (ocd_start_o),
        .ocd_end_o    (ocd_end_o),
        .lose_evt_o   (lose_evt),
        .lock_evt_o   (lock_evt)
    );

    atm_lcd_timer #(
        .PERIOD_W    (PERIOD_W),
        .SCALE_SHIFT (SCALE_SHIFT)
    ) u_lcd (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (lose_evt),
        .disarm_i    (lock_evt),
        .tick_i      (tick_i),
        .period_i    (lcd_period_i),
        .lcd_start_o (lcd_start_o),
        .lcd_end_o   (lcd_end_o)
    );

    p_hit_needs_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ok_o |-> $past(win_full));

    p_loss_and_lock_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ocd_start_o && ocd_end_o));

    p_alarm_outside_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_start_o |-> (status_o != 2'b10));

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (status_o == 2'b00 && !ocd_start_o && !lcd_start_o && !hdr_ok_o));

endmodule

// File: tb/atm_cell_delin_tb.sv
module atm_cell_delin_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  octet = 8'h00;
    logic        vld = 1'b0;
    logic [3:0]  alpha = 4'd7;
    logic [3:0]  delta = 4'd6;
    logic [7:0]  coset = 8'h55;
    logic        force_hunt = 1'b0;
    logic [15:0] lcd_period = 16'd2;
    logic        tick = 1'b1;
    logic        cell_start, hdr_ok, ocd_start, ocd_end, lcd_start, lcd_end;
    logic [1:0]  status;

    int checks = 0;
    int fails  = 0;
    int n_ocds = 0, n_ocde = 0, n_lcds = 0, n_lcde = 0;
    bit live = 1'b0;
    bit rand_tick = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atm_cell_delin u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .octet_i      (octet),
        .octet_vld_i  (vld),
        .alpha_i      (alpha),
        .delta_i      (delta),
        .coset_i      (coset),
        .force_hunt_i (force_hunt),
        .lcd_period_i (lcd_period),
        .tick_i       (tick),
        .cell_start_o (cell_start),
        .hdr_ok_o     (hdr_ok),
        .status_o     (status),
        .ocd_start_o  (ocd_start),
        .ocd_end_o    (ocd_end),
        .lcd_start_o  (lcd_start),
        .lcd_end_o    (lcd_end)
    );

    // Reference check code: polynomial division of the 32-bit header.
    function automatic logic [7:0] ref_hec(input logic [31:0] hdr, input logic [7:0] cs);
        logic [7:0] rem = 8'h00;
        for (int k = 31; k >= 0; k--) begin
            logic fb = rem[7] ^ hdr[k];
            rem = {rem[6:0], 1'b0};
            if (fb) rem = rem ^ 8'h07;
        end
        return rem ^ cs;
    endfunction

    // Behavioural reference model, evaluated on each rising edge.
    logic [7:0] hist[$];
    int  m_state = 0, m_pos = 0, m_good = 0, m_bad = 0, m_cnt = 0;
    bit  m_armed = 0, m_lact = 0;
    bit  e_hdr = 0, e_cell = 0, e_ocds = 0, e_ocde = 0, e_lcds = 0, e_lcde = 0;

    always @(posedge clk) begin
        bit hit, lose, lock;
        int aeff, deff;
        lose = 0; lock = 0;
        e_hdr = 0; e_cell = 0; e_ocds = 0; e_ocde = 0; e_lcds = 0; e_lcde = 0;
        aeff = (alpha == 0) ? 1 : int'(alpha);
        deff = (delta == 0) ? 1 : int'(delta);
        if (!rst_n) begin
            m_state = 0; m_pos = 0; m_good = 0; m_bad = 0; m_cnt = 0;
            m_armed = 0; m_lact = 0; hist.delete();
        end else begin
            if (force_hunt) begin
                m_state = 0; m_pos = 0; m_good = 0; m_bad = 0; hist.delete();
            end else if (vld) begin
                hit = (hist.size() == 4) &&
                      (ref_hec({hist[0], hist[1], hist[2], hist[3]}, coset) == octet);
                if (m_state == 0) begin
                    if (hit) begin
                        e_hdr = 1; m_state = 1; m_pos = 0; m_good = 0;
                    end
                end else if (m_pos == 52) begin
                    m_pos = 0; e_hdr = hit; e_cell = (m_state == 2);
                    if (m_state == 1) begin
                        if (!hit) begin m_state = 0; m_good = 0; end
                        else if (m_good + 1 >= deff) begin m_state = 2; m_good = 0; m_bad = 0; lock = 1; end
                        else m_good++;
                    end else begin
                        if (hit) m_bad = 0;
                        else if (m_bad + 1 >= aeff) begin m_state = 0; m_bad = 0; lose = 1; end
                        else m_bad++;
                    end
                end else begin
                    m_pos++;
                end
                hist.push_back(octet);
                if (hist.size() > 4) void'(hist.pop_front());
            end
            if (lock) begin
                e_lcde = m_lact; m_armed = 0; m_lact = 0;
            end else if (lose) begin
                m_armed = 1; m_lact = 0; m_cnt = 128 * int'(lcd_period);
            end else if (tick && m_armed && !m_lact) begin
                if (m_cnt <= 1) begin m_lact = 1; e_lcds = 1; end
                else m_cnt--;
            end
            e_ocds = lose; e_ocde = lock;
        end
        live = 1;
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            cmp("R3",  "status",     int'(status),     m_state);
            cmp("R1",  "hdr_ok",     int'(hdr_ok),     int'(e_hdr));
            cmp("R10", "cell_start", int'(cell_start), int'(e_cell));
            cmp("R6",  "ocd_start",  int'(ocd_start),  int'(e_ocds));
            cmp("R6",  "ocd_end",    int'(ocd_end),    int'(e_ocde));
            cmp("R7",  "lcd_start",  int'(lcd_start),  int'(e_lcds));
            cmp("R7",  "lcd_end",    int'(lcd_end),    int'(e_lcde));
            n_ocds += int'(ocd_start); n_ocde += int'(ocd_end);
            n_lcds += int'(lcd_start); n_lcde += int'(lcd_end);
            if (rand_tick) tick = ($urandom_range(0, 1) == 1);
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk); octet = b; vld = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); vld = 1'b0; end
    endtask

    task automatic zhdr(input logic [7:0] hec);
        repeat (4) put(8'h00);
        put(hec);
    endtask

    task automatic zcell(input logic [7:0] hec);
        zhdr(hec);
        repeat (48) put(8'h00);
    endtask

    task automatic rcell(input bit good, input bit gaps);
        logic [31:0] h = $urandom;
        logic [7:0] hec = ref_hec(h, coset) ^ (good ? 8'h00 : 8'h5A);
        for (int i = 3; i >= 0; i--) begin
            if (gaps && $urandom_range(0, 3) == 0) idle(1);
            put(h[i*8 +: 8]);
        end
        put(hec);
        for (int i = 0; i < 48; i++) begin
            if (gaps && $urandom_range(0, 3) == 0) idle(1);
            put(8'($urandom));
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int saved;
        repeat (3) @(negedge clk);
        cmp("R9", "reset status", int'(status), 0);
        cmp("R9", "reset pulses", int'(ocd_start | lcd_start | hdr_ok | cell_start), 0);
        rst_n = 1'b1;

        // Lock from search with default thresholds (alpha 7, delta 6).
        put(8'h11); put(8'h22); put(8'h33);
        repeat (6) zcell(8'h55);
        idle(1);
        cmp("R4", "candidate before delta", int'(status), 1);
        repeat (2) zcell(8'h55);
        idle(1);
        cmp("R4", "locked after delta", int'(status), 2);

        // Failure runs shorter than alpha keep lock.
        repeat (6) zcell(8'h00);
        zcell(8'h55);
        repeat (6) zcell(8'h00);
        idle(1);
        cmp("R5", "lock kept below alpha", int'(status), 2);
        zhdr(8'h00);
        idle(1);
        cmp("R5", "search after alpha", int'(status), 0);
        cmp("R6", "loss pulse", int'(ocd_start), 1);

        // Persistence timer: 2 x 128 ticks.
        repeat (200) put(8'h00);
        cmp("R7", "no alarm before period", n_lcds, 0);
        repeat (80) put(8'h00);
        cmp("R7", "alarm after period", n_lcds, 1);
        saved = n_ocde;
        repeat (8) zcell(8'h55);
        idle(1);
        cmp("R4", "relock", int'(status), 2);
        cmp("R6", "lock pulse count", n_ocde, saved + 1);
        cmp("R7", "alarm end count", n_lcde, 1);

        // Forced search from lock raises no loss event.
        saved = n_ocds;
        @(negedge clk); vld = 1'b0; force_hunt = 1'b1;
        idle(2);
        cmp("R8", "forced status", int'(status), 0);
        cmp("R8", "no loss pulse", n_ocds, saved);
        @(negedge clk); force_hunt = 1'b0;
        zhdr(8'h55);
        idle(1);
        cmp("R1", "zero header matches coset 0x55", int'(hdr_ok), 1);
        cmp("R2", "candidate after first match", int'(status), 1);
        repeat (48) put(8'h00);
        zhdr(8'h00);
        idle(1);
        cmp("R4", "candidate failure", int'(status), 0);

        // Idle cycles hold the locked state.
        repeat (8) zcell(8'h55);
        idle(20);
        cmp("R11", "status held over idle", int'(status), 2);
        cmp("R11", "no check pulse over idle", int'(hdr_ok), 0);

        // Random stream, other thresholds and coset, random ticks.
        alpha = 4'd2; delta = 4'd1; coset = 8'h00; lcd_period = 16'd1; rand_tick = 1'b1;
        for (int c = 0; c < 30; c++) rcell(1'b1, 1'b1);
        put(8'hC3);
        for (int c = 0; c < 30; c++) rcell($urandom_range(0, 4) != 0, 1'b1);
        for (int c = 0; c < 6; c++) rcell(1'b0, 1'b0);
        for (int c = 0; c < 10; c++) rcell(1'b1, 1'b0);
        rand_tick = 1'b0; tick = 1'b1;

        // Zero thresholds act as one.
        @(negedge clk); vld = 1'b0; force_hunt = 1'b1;
        @(negedge clk); force_hunt = 1'b0;
        alpha = 4'd0; delta = 4'd0; coset = 8'hA3;
        zcell(8'hA3);
        zhdr(8'hA3);
        idle(1);
        cmp("R12", "delta 0 locks after one check", int'(status), 2);
        repeat (48) put(8'h00);
        zhdr(8'h00);
        idle(1);
        cmp("R12", "alpha 0 loses after one failure", int'(status), 0);
        idle(5);
        finish_run();
    end
endmodule